// File: doc/BRIEF.md
# Self-Checking Radix-2 Signed-Digit Adder

This block adds two N-digit radix-2 signed-digit operands and returns an (N+1)-digit signed-digit sum without any carry chain longer than two digit positions. Every digit is held as a pair of bits, one meaning "minus one" and one meaning "plus one". The adder is made only of full-adder cells, two per digit position. The first level folds the positive bits of both operands and the complemented negative bit of operand A into an intermediate sum and a transfer bit. The second level merges that intermediate sum with operand B's negative bit and the transfer from the digit below.

Each full-adder cell watches itself. It compares "are all three inputs equal" with "are sum and carry equal", and raises its own error flag when the two relations disagree. Faults on the operand wires are not visible to the cells, so a separate parity check compares a parity supplied with the operands against the parity of the first-level sum bits together with operand B's negative bits. An odd number of flipped operand lines is caught this way. A stuck-at injection input (a per-line mask plus forced value) lets a testbench corrupt chosen wires and cell outputs. The datapath is purely combinational.

Top module: `sd_selfcheck_adder`

## Requirements
- R1: Digit i of an operand or of the result occupies bits [2i+1:2i]. Bit 2i is the positive bit and bit 2i+1 is the negative bit. The digit value is (positive − negative), so 01 means +1, 10 means −1, and both 00 and 11 mean 0. Operands may use either zero encoding.
- R2: With the injection mask all zero, the sum value Σ(pos−neg)·2^i over all N+1 digits equals the value of opA plus the value of opB.
- R3: Result digit i depends only on operand digits i, i−1 and i−2. Changing operand digit 0 leaves result digits 3..N unchanged.
- R4: With the injection mask all zero, every bit of cellErr is 0 for any operand values.
- R5: parErr equals parAB XOR (XOR of all first-level sum lines) XOR (XOR of all operand-B negative lines) XOR (1 when N is odd). It is therefore 0 when parAB is the XOR of all bits of opA and opB and no line is forced, and 1 when parAB is inverted.
- R6: Injection bit k·N+i selects line k of digit i, with k in this order: 0 A positive, 1 A negative, 2 B positive, 3 B negative, 4 first-level sum, 5 first-level carry (into digit i+1), 6 second-level sum (result positive bit i), 7 second-level carry (result negative bit of digit i+1, inverted). When the mask bit is set, the line takes the value of the matching injVal bit.
- R7: Forcing one operand line to the opposite of its driven value sets parErr, leaves cellErr at 0, and yields the sum of the corrupted operands.
- R8: The first-level cell of digit i computes (A pos, NOT A neg, B pos). The second-level cell computes (NOT B neg, first-level sum i, first-level carry from digit i−1, 0 for digit 0). Forcing one cell output to the opposite of its fault-free value sets exactly one cellErr bit: bit i for a first-level cell, bit N+i for a second-level cell.
- R9: Forcing any line to the value it already carries changes no output: the sum is identical and both flag outputs stay 0.
- R10: Forcing three distinct operand lines to their opposite values sets parErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 2N | Operand A, signed-digit pairs |
| opB | input | 2N | Operand B, signed-digit pairs |
| parAB | input | 1 | Supplied parity of all bits of opA and opB |
| injMask | input | 8N | Per-line force enable |
| injVal | input | 8N | Per-line forced value |
| sumZ | output | 2N+2 | Sum, N+1 signed-digit pairs |
| cellErr | output | 2N | Cell error flags: [N-1:0] first level, [2N-1:N] second level |
| parErr | output | 1 | Operand-line parity error |

## Verification
Every output is a combinational function of the inputs, so each result is due in the same cycle as its stimulus, with no register on the way. The bench changes inputs on the falling clock edge and samples 5 ns later, well before the next rising edge, so that all values have settled and no sample lands on an edge. Expected sums come from an independent integer evaluation of the digit pairs. Expected flag positions and forced-line values come from the cell input equations stated in the requirements.

// File: rtl/sdadd_pkg.sv
`timescale 1ns/1ps
package sdadd_pkg;
  localparam int SITE_A_POS    = 0;
  localparam int SITE_A_NEG    = 1;
  localparam int SITE_B_POS    = 2;
  localparam int SITE_B_NEG    = 3;
  localparam int SITE_L1_SUM   = 4;
  localparam int SITE_L1_CARRY = 5;
  localparam int SITE_L2_SUM   = 6;
  localparam int SITE_L2_CARRY = 7;
  localparam int SITE_COUNT    = 8;

  typedef struct packed {
    logic stuckLo;
    logic stuckHi;
  } stuckT;

  function automatic logic applyStuck(input logic nominal, input stuckT f);
    return f.stuckHi ? 1'b1 : (f.stuckLo ? 1'b0 : nominal);
  endfunction
endpackage

// File: rtl/sd_fault_ctrl.sv
`timescale 1ns/1ps
module sd_fault_ctrl #(
  parameter int N = 8
) (
  input  logic [sdadd_pkg::SITE_COUNT*N-1:0] injMask,
  input  logic [sdadd_pkg::SITE_COUNT*N-1:0] injVal,
  output sdadd_pkg::stuckT [sdadd_pkg::SITE_COUNT-1:0][N-1:0] stuck
);
  localparam int SITES = sdadd_pkg::SITE_COUNT;

  for (genvar k = 0; k < SITES; k++) begin : g_site
    for (genvar i = 0; i < N; i++) begin : g_digit
      localparam int IDX = k*N + i;
      assign stuck[k][i].stuckHi = injMask[IDX] &  injVal[IDX];
      assign stuck[k][i].stuckLo = injMask[IDX] & ~injVal[IDX];
    end
  end
endmodule

// File: rtl/sd_fa_cell.sv
`timescale 1ns/1ps
module sd_fa_cell (
  input  logic             x,
  input  logic             y,
  input  logic             cin,
  input  sdadd_pkg::stuckT sumFault,
  input  sdadd_pkg::stuckT carryFault,
  output logic             sum,
  output logic             cout,
  output logic             err
);
  logic sumRaw;
  logic carryRaw;
  logic allSame;
  logic eqt;
  logic g1;

  // sum and carry built from disjoint terms
  assign sumRaw   = x ^ y ^ cin;
  assign carryRaw = (x & y) | (x & cin) | (y & cin);

  assign sum  = sdadd_pkg::applyStuck(sumRaw, sumFault);
  assign cout = sdadd_pkg::applyStuck(carryRaw, carryFault);

  assign allSame = (x & y & cin) | (~x & ~y & ~cin);
  assign eqt     = ~allSame;
  assign g1      = ~(sum ^ cout);
  assign err     = ~(g1 ^ eqt);
endmodule

// File: rtl/sd_add_datapath.sv
`timescale 1ns/1ps
module sd_add_datapath #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] opA,
  input  logic [2*N-1:0] opB,
  input  sdadd_pkg::stuckT [sdadd_pkg::SITE_COUNT-1:0][N-1:0] stuck,
  output logic [2*N+1:0] sumZ,
  output logic [2*N-1:0] cellErr,
  output logic [N-1:0]   sumLine,
  output logic [N-1:0]   bNegLine
);
  import sdadd_pkg::*;

  logic [N-1:0] aPos;
  logic [N-1:0] aNeg;
  logic [N-1:0] bPos;
  logic [N:0]   hLine;
  logic [N:1]   cLine;
  logic [N-1:0] zPos;

  assign hLine[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_digit
    assign aPos[i]     = applyStuck(opA[2*i],   stuck[SITE_A_POS][i]);
    assign aNeg[i]     = applyStuck(opA[2*i+1], stuck[SITE_A_NEG][i]);
    assign bPos[i]     = applyStuck(opB[2*i],   stuck[SITE_B_POS][i]);
    assign bNegLine[i] = applyStuck(opB[2*i+1], stuck[SITE_B_NEG][i]);

    sd_fa_cell u_lvl1 (
      .x          (aPos[i]),
      .y          (~aNeg[i]),
      .cin        (bPos[i]),
      .sumFault   (stuck[SITE_L1_SUM][i]),
      .carryFault (stuck[SITE_L1_CARRY][i]),
      .sum        (sumLine[i]),
      .cout       (hLine[i+1]),
      .err        (cellErr[i])
    );

    sd_fa_cell u_lvl2 (
      .x          (~bNegLine[i]),
      .y          (sumLine[i]),
      .cin        (hLine[i]),
      .sumFault   (stuck[SITE_L2_SUM][i]),
      .carryFault (stuck[SITE_L2_CARRY][i]),
      .sum        (zPos[i]),
      .cout       (cLine[i+1]),
      .err        (cellErr[N+i])
    );

    assign sumZ[2*i] = zPos[i];
    if (i == 0) begin : g_low
      assign sumZ[1] = hLine[0];
    end else begin : g_mid
      assign sumZ[2*i+1] = ~cLine[i];
    end
  end

  assign sumZ[2*N]   = hLine[N];
  assign sumZ[2*N+1] = ~cLine[N];
endmodule

// File: rtl/sd_parity_check.sv
`timescale 1ns/1ps
module sd_parity_check #(
  parameter int N = 8
) (
  input  logic [N-1:0] sumLine,
  input  logic [N-1:0] bNegLine,
  input  logic         parAB,
  output logic         parErr
);
  localparam logic ODD_DIGITS = 1'((N % 2) == 1);

  assign parErr = parAB ^ (^sumLine) ^ (^bNegLine) ^ ODD_DIGITS;
endmodule

// File: rtl/sd_selfcheck_adder.sv
`timescale 1ns/1ps
module sd_selfcheck_adder #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] opA,
  input  logic [2*N-1:0] opB,
  input  logic           parAB,
  input  logic [8*N-1:0] injMask,
  input  logic [8*N-1:0] injVal,
  output logic [2*N+1:0] sumZ,
  output logic [2*N-1:0] cellErr,
  output logic           parErr
);
  sdadd_pkg::stuckT [sdadd_pkg::SITE_COUNT-1:0][N-1:0] stuck;
  logic [N-1:0] sumLine;
  logic [N-1:0] bNegLine;

  sd_fault_ctrl #(.N(N)) u_ctrl (
    .injMask (injMask),
    .injVal  (injVal),
    .stuck   (stuck)
  );

  sd_add_datapath #(.N(N)) u_path (
    .opA      (opA),
    .opB      (opB),
    .stuck    (stuck),
    .sumZ     (sumZ),
    .cellErr  (cellErr),
    .sumLine  (sumLine),
    .bNegLine (bNegLine)
  );

  sd_parity_check #(.N(N)) u_par (
    .sumLine  (sumLine),
    .bNegLine (bNegLine),
    .parAB    (parAB),
    .parErr   (parErr)
  );
endmodule

// File: rtl/sd_selfcheck_adder_chk.sv
`timescale 1ns/1ps
module sd_selfcheck_adder_chk #(
  parameter int N = 8
) (
  input logic [2*N-1:0] opA,
  input logic [2*N-1:0] opB,
  input logic           parAB,
  input logic [8*N-1:0] injMask,
  input logic [2*N+1:0] sumZ,
  input logic [2*N-1:0] cellErr,
  input logic           parErr
);
  function automatic longint pairValue(input logic [2*N+1:0] v);
    longint acc = 0;
    for (int k = 0; k <= N; k++) begin
      acc = acc + (longint'(v[2*k]) << k) - (longint'(v[2*k+1]) << k);
    end
    return acc;
  endfunction

  always_comb begin
    if (injMask == '0) begin
      assert_cells_quiet_R4: assert (cellErr == '0)
        else $error("cell flag raised with nothing forced");
      assert_sum_exact_R2: assert (pairValue(sumZ) ==
                                   pairValue({2'b00, opA}) + pairValue({2'b00, opB}))
        else $error("sum value differs from operand total");
    end
    if (injMask[5*N-1:0] == '0 && parAB == ^{opA, opB}) begin
      assert_parity_quiet_R5: assert (!parErr)
        else $error("parity flag raised on clean operand lines");
    end
    // R8: only a forced cell output may raise a cell flag
    assert_flag_bound_R8: assert ($countones(cellErr) <= $countones(injMask[8*N-1:4*N]))
      else $error("more cell flags than forced cell outputs");
  end
endmodule

bind sd_selfcheck_adder sd_selfcheck_adder_chk #(.N(N)) u_chk (.*);

// File: tb/sd_selfcheck_adder_tb.sv
`timescale 1ns/1ps
module sd_selfcheck_adder_tb;
  localparam int N = 8;
  localparam int W = 2*N;
  localparam int L = 8*N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]  opA, opB;
  logic          parAB;
  logic [L-1:0]  injMask, injVal;
  logic [W+1:0]  sumZ;
  logic [W-1:0]  cellErr;
  logic          parErr;

  int vecCount  = 0;
  int missCount = 0;
  bit done      = 1'b0;

  sd_selfcheck_adder #(.N(N)) u_dut (
    .opA(opA), .opB(opB), .parAB(parAB), .injMask(injMask), .injVal(injVal),
    .sumZ(sumZ), .cellErr(cellErr), .parErr(parErr)
  );

  function automatic longint sdVal(input logic [W+1:0] v);
    longint acc = 0;
    for (int k = 0; k <= N; k++) begin
      if (v[2*k])   acc += (longint'(1) << k);
      if (v[2*k+1]) acc -= (longint'(1) << k);
    end
    return acc;
  endfunction

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic l1Sum(input logic [W-1:0] a, input logic [W-1:0] b, input int j);
    return a[2*j] ^ ~a[2*j+1] ^ b[2*j];
  endfunction

  function automatic logic l1Carry(input logic [W-1:0] a, input logic [W-1:0] b, input int j);
    return maj3(a[2*j], ~a[2*j+1], b[2*j]);
  endfunction

  function automatic logic carryIn(input logic [W-1:0] a, input logic [W-1:0] b, input int j);
    return (j == 0) ? 1'b0 : l1Carry(a, b, j-1);
  endfunction

  function automatic logic nominalLine(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input int site, input int j);
    case (site)
      0: return a[2*j];
      1: return a[2*j+1];
      2: return b[2*j];
      3: return b[2*j+1];
      4: return l1Sum(a, b, j);
      5: return l1Carry(a, b, j);
      6: return ~b[2*j+1] ^ l1Sum(a, b, j) ^ carryIn(a, b, j);
      default: return maj3(~b[2*j+1], l1Sum(a, b, j), carryIn(a, b, j));
    endcase
  endfunction

  task automatic expectEq(input string req, input longint act, input longint exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                       input logic [L-1:0] m, input logic [L-1:0] v);
    @(negedge clk);
    opA = a; opB = b; parAB = p; injMask = m; injVal = v;
    #5;
  endtask

  function automatic logic [W+1:0] ext(input logic [W-1:0] v);
    return {2'b00, v};
  endfunction

  task automatic tResetState();
    drive('0, '0, 1'b0, '0, '0);
    expectEq("R1 zero operands give zero bits", longint'(sumZ), 0);
    expectEq("R4 quiet cells at zero", longint'(cellErr), 0);
    expectEq("R5 quiet parity at zero", longint'(parErr), 0);
  endtask

  task automatic tRandomSum();
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      drive(a, b, ^{a, b}, '0, '0);
      expectEq("R2 random sum (R1 mixed zeros)", sdVal(sumZ), sdVal(ext(a)) + sdVal(ext(b)));
      expectEq("R4 random cells quiet", longint'(cellErr), 0);
      expectEq("R5 random parity quiet", longint'(parErr), 0);
    end
  endtask

  task automatic tExtremes();
    logic [W-1:0] allPos, allNeg, allOnes;
    allPos = '0; allNeg = '0; allOnes = '1;
    for (int j = 0; j < N; j++) begin
      allPos[2*j] = 1'b1; allNeg[2*j+1] = 1'b1;
    end
    drive(allPos, allPos, ^{allPos, allPos}, '0, '0);
    expectEq("R2 max positive", sdVal(sumZ), 2*((longint'(1) << N) - 1));
    drive(allNeg, allNeg, ^{allNeg, allNeg}, '0, '0);
    expectEq("R2 max negative", sdVal(sumZ), -2*((longint'(1) << N) - 1));
    drive(allPos, allNeg, ^{allPos, allNeg}, '0, '0);
    expectEq("R2 cancel", sdVal(sumZ), 0);
    drive(allOnes, allOnes, 1'b0, '0, '0);
    expectEq("R1 zero as 11", sdVal(sumZ), 0);
    expectEq("R4 zero as 11 cells", longint'(cellErr), 0);
  endtask

  task automatic tLocality();
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b, a2;
      logic [W+1:0] first;
      a = W'($urandom); b = W'($urandom);
      a2 = {a[W-1:2], 2'(n)};
      drive(a, b, ^{a, b}, '0, '0);
      first = sumZ;
      drive(a2, b, ^{a2, b}, '0, '0);
      expectEq("R3 upper digits unchanged", longint'(sumZ[W+1:6]), longint'(first[W+1:6]));
    end
  endtask

  task automatic tParityFlag();
    for (int n = 0; n < 10; n++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      drive(a, b, ~(^{a, b}), '0, '0);
      expectEq("R5 inverted parity flagged", longint'(parErr), 1);
      expectEq("R5 inverted parity cells quiet", longint'(cellErr), 0);
    end
  endtask

  task automatic tOperandFault();
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, b, af, bf;
      logic [L-1:0] m, v;
      int site, j;
      logic nom;
      a = W'($urandom); b = W'($urandom);
      site = n % 4; j = int'($urandom % N);
      nom = nominalLine(a, b, site, j);
      m = '0; v = '0;
      m[site*N + j] = 1'b1; v[site*N + j] = ~nom;
      af = a; bf = b;
      case (site)
        0: af[2*j]   = ~nom;
        1: af[2*j+1] = ~nom;
        2: bf[2*j]   = ~nom;
        default: bf[2*j+1] = ~nom;
      endcase
      drive(a, b, ^{a, b}, m, v);
      expectEq("R7 operand fault flagged", longint'(parErr), 1);
      expectEq("R7 operand fault cells quiet", longint'(cellErr), 0);
      expectEq("R6 forced operand value used", sdVal(sumZ), sdVal(ext(af)) + sdVal(ext(bf)));
    end
  endtask

  task automatic tCellFault();
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, b;
      logic [L-1:0] m, v;
      int site, j;
      logic nom;
      a = W'($urandom); b = W'($urandom);
      site = 4 + (n % 4); j = int'($urandom % N);
      nom = nominalLine(a, b, site, j);
      m = '0; v = '0;
      m[site*N + j] = 1'b1; v[site*N + j] = ~nom;
      drive(a, b, ^{a, b}, m, v);
      expectEq("R8 single cell flag", longint'(cellErr),
               longint'(1) << ((site < 6) ? j : N + j));
      expectEq("R5 parity under cell fault", longint'(parErr), (site == 4) ? 1 : 0);
    end
  endtask

  task automatic tBenignForce();
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, b;
      logic [W+1:0] base;
      logic [L-1:0] m, v;
      int site, j;
      a = W'($urandom); b = W'($urandom);
      site = n % 8; j = int'($urandom % N);
      drive(a, b, ^{a, b}, '0, '0);
      base = sumZ;
      m = '0; v = '0;
      m[site*N + j] = 1'b1; v[site*N + j] = nominalLine(a, b, site, j);
      drive(a, b, ^{a, b}, m, v);
      expectEq("R9 benign force sum", longint'(sumZ), longint'(base));
      expectEq("R9 benign force flags", longint'({cellErr, parErr}), 0);
    end
  endtask

  task automatic tTripleFault();
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b;
      logic [L-1:0] m, v;
      int site, j0;
      a = W'($urandom); b = W'($urandom);
      site = n % 4; j0 = int'($urandom % N);
      m = '0; v = '0;
      for (int t = 0; t < 3; t++) begin
        int jj;
        jj = (j0 + t) % N;
        m[site*N + jj] = 1'b1;
        v[site*N + jj] = ~nominalLine(a, b, site, jj);
      end
      drive(a, b, ^{a, b}, m, v);
      expectEq("R10 three operand faults flagged", longint'(parErr), 1);
    end
  endtask

  initial begin
    opA = '0; opB = '0; parAB = 1'b0; injMask = '0; injVal = '0;
    tResetState();
    tRandomSum();
    tExtremes();
    tLocality();
    tParityFlag();
    tOperandFault();
    tCellFault();
    tBenignForce();
    tTripleFault();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      missCount++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule